// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policy

This block is a direct-mapped cache that sits between a CPU request port and a word-wide main-memory bus. The memory bus has separate read and write strobes, each held until the memory acknowledges it. Each cache line holds one data word together with a tag, a valid flag and a modified flag. A static mode input selects one of two write policies.

With `mode_wt` low, the controller defers memory writes. A write hit only changes the line and marks it modified. A write miss first fetches the word from memory and then merges the write into the line. A modified line that is being replaced is written back to memory before the new word is read in.

With `mode_wt` high, the controller writes through and does not allocate on a write. Every CPU write is posted into a small queue that drains to memory in the background. A write hit also updates the cached copy. A write miss leaves the cache untouched.

The controller also keeps a saturating count of completed memory-bus writes, which software or a neighbouring block can clear synchronously.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 while no request is pending, both memory strobes are 0, `wr_count` is 0 and every line is invalid, so the first access to any address misses.
- R2: A read that hits is accepted in the cycle it is presented, with no stall and no memory-bus access. `rsp_valid` is then 1 for one cycle on the next clock, with the cached word on `rsp_rdata`.
- R3: With `mode_wt`=0, a write hit changes only the cached word and marks the line modified. It causes no memory-bus write.
- R4: With `mode_wt`=0, a miss on a valid modified line first writes the old word to its old address with `mem_wr`, and only after that write is acknowledged reads the new address with `mem_rd`. The two strobes are never high together.
- R5: A line refilled by a read miss is unmodified, so replacing it later costs one memory read and no memory write.
- R6: With `mode_wt`=0, a write miss reads the addressed word from memory, then applies the CPU write to the line and marks it modified.
- R7: With `mode_wt`=1, every accepted CPU write produces exactly one memory write of that word. A write hit also updates the cached word, and the CPU is stalled only while the posted queue is full.
- R8: With `mode_wt`=1, a write miss writes memory and does not install the address, so a later read of that address misses and reads memory.
- R9: With `mode_wt`=1, a read miss does not raise `mem_rd` until every posted write has been acknowledged, so it never returns stale data.
- R10: With `mode_wt`=1, replacing a line never causes a write-back. The only memory writes are the posted CPU writes.
- R11: `wr_count` rises by one for each acknowledged memory write and holds at its all-ones maximum. A `cnt_clr` pulse sets it to 0 on the next clock.
- R12: `req_ready` is 0 from the cycle a miss or a full-queue stall is seen until the access can complete. Each memory strobe stays high until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wt | input | 1 | 0: deferred write with allocate; 1: write-through without allocate (static) |
| cnt_clr | input | 1 | Synchronous clear of `wr_count` |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | DATA_W | Read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the strobed access |
| wr_count | output | CNT_W | Saturating count of memory writes |

## Verification
A wrong modified flag shows up at the memory port on the next conflicting miss. If the flag is lost, the miss skips the write and memory keeps the old word. If the flag is stuck on, an unmodified line costs an extra write, and `wr_count` is off by one within a single miss sequence. A wrong tag or data word in a line appears on `rsp_rdata` one cycle after the next read of that index. A queue that gives up a posted write too early, or lets a refill start ahead of it, is caught at the first `mem_rd` that rises while bench-tracked writes are still unacknowledged.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_e;

    // A request needs a line to be brought in unless it is a write under
    // the write-through / no-allocate pairing.
    function automatic logic needs_alloc(input logic is_write, input logic wt_mode);
        return !is_write || !wt_mode;
    endfunction

    // Only the deferred-write pairing ever keeps a modified copy.
    function automatic logic must_write_back(input logic wt_mode, input logic v, input logic m);
        return !wt_mode && v && m;
    endfunction

endpackage

// File: rtl/dm_line_store.sv
module dm_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic              lk_mod,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_mod,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] mod_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            mod_q   <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= 1'b1;
            mod_q[wr_idx]   <= wr_mod;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_mod   = mod_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx];
endmodule

// File: rtl/dm_post_buf.sv
module dm_post_buf #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_q[wp] <= push_addr;
            data_q[wp] <= push_data;
        end
    end

    assign head_addr = addr_q[rp];
    assign head_data = data_q[rp];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
endmodule

// File: rtl/dm_wr_counter.sv
module dm_wr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)                count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
    import dm_cache_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 3,
    parameter int DATA_W     = 16,
    parameter int WBUF_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wt,
    input  logic              cnt_clr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  wr_count
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_e state, state_nx;
    logic [ADDR_W-1:0] miss_addr;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid, lk_mod;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;

    logic              st_we, st_mod;
    logic [IDX_W-1:0]  st_idx;
    logic [TAG_W-1:0]  st_tag;
    logic [DATA_W-1:0] st_data;

    logic              wb_push, wb_pop, wb_empty, wb_full;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    logic hit, alloc_miss, wt_write, stall, accept, start_miss;

    // Lookup follows the CPU address while idle, the held miss otherwise.
    assign lk_idx = (state == ST_IDLE) ? req_addr[IDX_W-1:0] : miss_addr[IDX_W-1:0];

    dm_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_mod(lk_mod),
        .lk_tag(lk_tag), .lk_data(lk_data),
        .we(st_we), .wr_idx(st_idx), .wr_mod(st_mod),
        .wr_tag(st_tag), .wr_data(st_data)
    );

    dm_post_buf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)) u_post (
        .clk(clk), .rst(rst),
        .push(wb_push), .push_addr(req_addr), .push_data(req_wdata),
        .pop(wb_pop), .head_addr(wb_addr), .head_data(wb_data),
        .empty(wb_empty), .full(wb_full)
    );

    dm_wr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr),
        .inc(mem_wr && mem_ack), .count(wr_count)
    );

    assign hit        = lk_valid && (lk_tag == req_addr[ADDR_W-1:IDX_W]);
    assign alloc_miss = req_valid && !hit && needs_alloc(req_write, mode_wt);
    assign wt_write   = mode_wt && req_write;
    assign stall      = alloc_miss || (wt_write && wb_full);
    assign req_ready  = (state == ST_IDLE) && !(req_valid && stall);
    assign accept     = req_valid && req_ready;
    // A refill under write-through waits for every posted write to drain.
    assign start_miss = (state == ST_IDLE) && alloc_miss && !(mode_wt && !wb_empty);
    assign wb_push    = accept && wt_write;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start_miss)
                          state_nx = must_write_back(mode_wt, lk_valid, lk_mod) ? ST_EVICT : ST_FILL;
            ST_EVICT: if (mem_ack) state_nx = ST_FILL;
            ST_FILL:  if (mem_ack) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            miss_addr <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= state_nx;
            if (start_miss) miss_addr <= req_addr;
            rsp_valid <= accept && !req_write;
            if (accept && !req_write) rsp_rdata <= lk_data;
        end
    end

    // Line updates: CPU write hit while idle, or refill data on acknowledge.
    always_comb begin
        st_we   = 1'b0;
        st_idx  = req_addr[IDX_W-1:0];
        st_tag  = req_addr[ADDR_W-1:IDX_W];
        st_data = req_wdata;
        st_mod  = !mode_wt;
        if (state == ST_FILL) begin
            st_we   = mem_ack;
            st_idx  = miss_addr[IDX_W-1:0];
            st_tag  = miss_addr[ADDR_W-1:IDX_W];
            st_data = mem_rdata;
            st_mod  = 1'b0;
        end else if (state == ST_IDLE) begin
            st_we   = accept && req_write && hit;
        end
    end

    // Memory bus: eviction, refill, or background drain of posted writes.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = wb_addr;
        mem_wdata = wb_data;
        wb_pop    = 1'b0;
        case (state)
            ST_EVICT: begin
                mem_wr    = 1'b1;
                mem_addr  = {lk_tag, miss_addr[IDX_W-1:0]};
                mem_wdata = lk_data;
            end
            ST_FILL: begin
                mem_rd   = 1'b1;
                mem_addr = miss_addr;
            end
            default: begin
                mem_wr = !wb_empty;
                wb_pop = !wb_empty && mem_ack;
            end
        endcase
    end
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk
    import dm_cache_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_wt,
    input logic             cnt_clr,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             mem_ack,
    input logic [CNT_W-1:0] wr_count,
    input ctl_state_e       state,
    input logic             wb_empty
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_deferred_no_direct_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_wt && mem_wr) |-> (state == ST_EVICT));

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_fill_after_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_wt && mem_rd) |-> wb_empty);

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(cnt_clr) |-> (wr_count == $past(wr_count) ||
                             {1'b0, wr_count} == {1'b0, $past(wr_count)} + 1'b1));

    assert_cnt_hold_top_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_count) == TOP && !$past(cnt_clr)) |-> (wr_count == TOP));

    assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_clr) |-> (wr_count == '0));

    assert_not_ready_on_refill_R12: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !req_ready);

    assert_rd_strobe_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ack) |=> mem_rd);

    assert_wr_strobe_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> mem_wr);
endmodule

bind dm_cache_ctrl dm_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .mode_wt(mode_wt), .cnt_clr(cnt_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .rsp_valid(rsp_valid), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack),
    .wr_count(wr_count), .state(state), .wb_empty(wb_empty)
);

// File: tb/sim_dm_cache_ctrl.sv
module sim_dm_cache_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_wt = 1'b0, cnt_clr = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_rd, mem_wr;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic [CW-1:0] wr_count;

    always #5 clk = ~clk;

    dm_cache_ctrl #(.ADDR_W(AW), .IDX_W(3), .DATA_W(DW), .WBUF_DEPTH(2), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .mode_wt(mode_wt), .cnt_clr(cnt_clr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .wr_count(wr_count)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [256];
    logic [DW-1:0] shadow [256];
    int lat = 0;
    int rd_acks = 0, wr_acks = 0;
    bit          log_wr [$];
    logic [AW-1:0] log_addr [$];

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 7 + 16'h1000);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat     <= 0;
        end else if ((mem_rd || mem_wr) && !mem_ack) begin
            if (lat == 2) begin
                mem_ack <= 1'b1;
                lat     <= 0;
                log_wr.push_back(mem_wr);
                log_addr.push_back(mem_addr);
                if (mem_wr) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_acks <= wr_acks + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_acks <= rd_acks + 1;
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            lat     <= 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [DW-1:0] d;
        string         tag;
    } exp_t;
    exp_t sb_q [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL R2 actual=%h expected=no response", rsp_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_rdata !== e.d) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, rsp_rdata, e.d);
                end
            end
        end
    end

    // Write-through ordering watch: no refill read while posted writes are unacked.
    int wt_acc = 0;
    int wr_base = 0;
    bit r9_seen = 0;
    always @(negedge clk) begin
        if (!rst && mode_wt && mem_rd && (wr_acks - wr_base) != wt_acc) r9_seen = 1;
    end

    task automatic cpu_acc(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag, output int stalls);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        stalls = 0;
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        if (!wr) sb_q.push_back('{shadow[a], tag});
        else     shadow[a] = d;
        if (mode_wt && wr) wt_acc++;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst = 1'b1;
        mode_wt = m;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        wr_base = wr_acks;
        wt_acc = 0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int st, rd0, wr0, n;
        do_reset(1'b0);

        // R1: reset state
        #1;
        check("R1 ready", req_ready, 1);
        check("R1 mem_rd", mem_rd, 0);
        check("R1 mem_wr", mem_wr, 0);
        check("R1 wr_count", wr_count, 0);

        // ---------- deferred write / allocate ----------
        rd0 = rd_acks;
        cpu_acc(0, 8'h05, 0, "R1 first read", st);
        check("R1 first access misses", rd_acks - rd0, 1);
        check("R12 miss stalls", st > 0, 1);

        rd0 = rd_acks; wr0 = wr_acks;
        cpu_acc(0, 8'h05, 0, "R2 hit data", st);
        idle(2);
        check("R2 hit no stall", st, 0);
        check("R2 hit no bus", (rd_acks - rd0) + (wr_acks - wr0), 0);

        wr0 = wr_acks;
        cpu_acc(1, 8'h05, 16'h1111, "R3", st);
        idle(8);
        check("R3 write hit no bus write", wr_acks - wr0, 0);
        check("R3 write hit no stall", st, 0);
        cpu_acc(0, 8'h05, 0, "R3 read back", st);

        cpu_acc(0, 8'h0D, 0, "R4 refill data", st);
        idle(2);
        n = log_wr.size();
        check("R4 evict is write", log_wr[n-2], 1);
        check("R4 evict addr", log_addr[n-2], 8'h05);
        check("R4 then read", log_wr[n-1], 0);
        check("R4 read addr", log_addr[n-1], 8'h0D);
        check("R4 memory updated", mem[8'h05], 16'h1111);
        check("R11 count after evict", wr_count, 1);

        rd0 = rd_acks; wr0 = wr_acks;
        cpu_acc(0, 8'h15, 0, "R5 data", st);
        idle(2);
        check("R5 clean replace reads", rd_acks - rd0, 1);
        check("R5 clean replace no write", wr_acks - wr0, 0);

        rd0 = rd_acks; wr0 = wr_acks;
        cpu_acc(1, 8'h22, 16'h2222, "R6", st);
        idle(2);
        check("R6 write miss reads", rd_acks - rd0, 1);
        check("R6 write miss no write", wr_acks - wr0, 0);
        cpu_acc(0, 8'h22, 0, "R6 merged data", st);
        cpu_acc(0, 8'h2A, 0, "R6 conflict data", st);
        idle(2);
        check("R6 line was modified", mem[8'h22], 16'h2222);
        check("R11 count 2", wr_count, 2);

        for (int k = 0; k < 8; k++)
            cpu_acc(1, AW'(8'h03 + 8 * k), DW'(16'h3000 + k), "R11 fill", st);
        idle(2);
        check("R11 saturates", wr_count, 7);
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        check("R11 clear", wr_count, 0);
        cpu_acc(1, 8'h43, 16'h4343, "R11 after clear", st);
        idle(2);
        check("R11 count after clear", wr_count, 1);
        check("R4 evicted word", mem[8'h3B], 16'h3007);

        // ---------- write-through / no allocate ----------
        do_reset(1'b1);
        cpu_acc(0, 8'h05, 0, "R2 wt fill", st);
        cpu_acc(1, 8'h05, 16'h3333, "R7", st);
        check("R7 posted write no stall", st, 0);
        idle(10);
        check("R7 memory written", mem[8'h05], 16'h3333);
        check("R7 one bus write", wr_count, 1);
        cpu_acc(0, 8'h05, 0, "R7 cached copy updated", st);

        cpu_acc(1, 8'h31, 16'h4444, "R8", st);
        check("R8 no stall", st, 0);
        idle(10);
        check("R8 memory written", mem[8'h31], 16'h4444);
        rd0 = rd_acks;
        cpu_acc(0, 8'h31, 0, "R8 read data", st);
        idle(2);
        check("R8 not installed", rd_acks - rd0, 1);

        cpu_acc(1, 8'h05, 16'h5555, "R9", st);
        cpu_acc(0, 8'h0D, 0, "R9 miss data", st);
        cpu_acc(0, 8'h05, 0, "R9 fresh data", st);
        idle(2);
        check("R9 no refill before drain", r9_seen, 0);
        check("R10 only posted writes", wr_count, 3);

        n = 0;
        for (int k = 0; k < 4; k++) begin
            cpu_acc(1, 8'h05, DW'(16'h6000 + k), "R7 burst", st);
            n += st;
        end
        check("R12 full queue stalls", n > 0, 1);
        idle(20);
        check("R7 last burst word", mem[8'h05], 16'h6003);
        check("R11 saturated wt", wr_count, 7);
        check("R7 bus writes match CPU writes", wr_acks - wr_base, wt_acc);
        check("R2 scoreboard drained", sb_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule